// File: doc/BRIEF.md
# Sequencer Branch Decision and Target Address Unit

This block sits in the transfer-control path of a small bus-controller sequencer. Each cycle the decoder can present one jump, call or interrupt instruction with its fields already split out. The block checks the enabled conditions against the live machine state: the ALU carry, the bus phase latched on the request strobe, the first byte received, and the attention line in target mode. From that it decides whether the branch is taken. It also works out the next execution address, which is either an absolute 32-bit address or the sequential address plus a signed 24-bit offset.

All results are registered. A result appears one cycle after the instruction is accepted and lasts for that single cycle. A data or phase compare can be told to wait for a valid phase. In that case the instruction is not accepted while no valid phase is latched, and the caller keeps `instr_valid` high until a result comes back. A taken call raises a return-address save strobe. A taken interrupt either asks the sequencer to halt or, when the on-the-fly bit is set, raises a one-cycle status pulse and lets execution continue. A carry test combined with a data or phase compare is reported as illegal.

Top module: `brcond_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every output is 0.
- R2: An instruction is accepted when `instr_valid` is 1 and it is not being held back by R13. Its result appears one clock later, with `res_valid` = 1 for that one cycle. While `res_valid` is 0, `branch_taken`, `ret_save`, `halt_req`, `int_fly` and `illegal` are all 0.
- R3: `ctrl` holds instruction bits 23..16, with `ctrl[3]` (bit 19) selecting the branch sense. When `ctrl[3]` = 1, the branch is taken only if every enabled test is true. When no test is enabled, the branch is always taken.
- R4: When `ctrl[3]` = 0, the branch is taken only if at least one test is enabled and every enabled test is false. When the data and phase tests are both enabled and give different outcomes, no branch is taken under either sense.
- R5: The data test is enabled by `ctrl[2]` (bit 18). It is true when `first_byte` equals `cmp_data`.
- R6: The phase test is enabled by `ctrl[1]` (bit 17). In initiator mode (`target_mode` = 0) it is true when `bus_phase` equals `phase_field`. In target mode it is true when `atn_active` = 1.
- R7: The carry test is enabled by `ctrl[5]` (bit 21). It is true when `alu_carry` = 1.
- R8: If `ctrl[5]` is set together with `ctrl[2]` or `ctrl[1]`, the result has `illegal` = 1, `branch_taken` = 0 and `next_pc` = `pc_seq`, and no save, halt or interrupt strobe is raised.
- R9: For a taken jump or call, `ctrl[7]` (bit 23) = 1 gives `next_pc` = `pc_seq` + sign-extended `addr_field[23:0]`, wrapping modulo 2^32. `ctrl[7]` = 0 gives `next_pc` = `addr_field`.
- R10: For a branch that is not taken, and for any interrupt, `next_pc` = `pc_seq`.
- R11: `op` is encoded as 0 = jump, 1 = call, 2 = interrupt, 3 = reserved (acts as jump). A taken call gives `ret_save` = 1 and `ret_addr` = `pc_seq`. A jump never raises `ret_save`.
- R12: A taken interrupt with `ctrl[4]` (bit 20) = 0 gives `halt_req` = 1. With `ctrl[4]` = 1 it gives `int_fly` = 1 and `halt_req` = 0. A jump or call never raises either strobe.
- R13: When `ctrl[0]` (bit 16) = 1, the data or phase test is enabled and `phase_valid` = 0, the instruction is not accepted and no result appears. The result follows one cycle after `phase_valid` rises. A carry-only instruction is never held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A transfer-control instruction is presented |
| op | input | 2 | Opcode: jump, call, interrupt, reserved |
| ctrl | input | 8 | Instruction bits 23..16 |
| phase_field | input | 3 | Phase to compare against |
| cmp_data | input | 8 | Data-to-compare field |
| addr_field | input | 32 | Absolute address, or offset in the low 24 bits |
| pc_seq | input | 32 | Address of the following instruction |
| alu_carry | input | 1 | ALU carry flag |
| bus_phase | input | 3 | Bus phase latched on the request strobe |
| phase_valid | input | 1 | A valid phase has been latched |
| first_byte | input | 8 | First byte received from the bus |
| atn_active | input | 1 | Attention line active (target mode) |
| target_mode | input | 1 | 1 = target, 0 = initiator |
| res_valid | output | 1 | Result cycle |
| branch_taken | output | 1 | Condition met and branch taken |
| next_pc | output | 32 | Next execution address |
| ret_save | output | 1 | Save the return address (taken call) |
| ret_addr | output | 32 | Return address to save |
| halt_req | output | 1 | Halt the sequencer (taken interrupt) |
| int_fly | output | 1 | Interrupt-on-the-fly status pulse |
| illegal | output | 1 | Carry test combined with a compare |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 24-bit offset, a 3-bit phase and an 8-bit data byte. With these widths the offset's sign bit is bit 23. That lets the bench reach a backward branch and a sum that wraps past the top of the 32-bit space. The 3-bit phase lets a phase match and a phase mismatch both be set up while the data test agrees or disagrees, so every mixed outcome of the two compares is covered.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
  typedef enum logic [1:0] {
    OP_JUMP = 2'd0,
    OP_CALL = 2'd1,
    OP_INT  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  // Bit positions inside ctrl (instruction bits 23..16)
  localparam int unsigned C_REL   = 7;
  localparam int unsigned C_CARRY = 5;
  localparam int unsigned C_FLY   = 4;
  localparam int unsigned C_SENSE = 3;
  localparam int unsigned C_DATA  = 2;
  localparam int unsigned C_PHASE = 1;
  localparam int unsigned C_WAIT  = 0;

  localparam int unsigned NUM_TESTS = 3;

  typedef struct packed {
    logic taken;
    logic save;
    logic halt;
    logic fly;
    logic illegal;
  } strobes_t;
endpackage

// File: rtl/brcond_eval.sv
module brcond_eval
  import brcond_pkg::*;
#(
  parameter int unsigned PH_W  = 3,
  parameter int unsigned DAT_W = 8
) (
  input  logic [7:0]       ctrl,
  input  logic [PH_W-1:0]  phase_field,
  input  logic [DAT_W-1:0] cmp_data,
  input  logic             alu_carry,
  input  logic [PH_W-1:0]  bus_phase,
  input  logic [DAT_W-1:0] first_byte,
  input  logic             atn_active,
  input  logic             target_mode,
  output logic             cond_met,
  output logic             bad_combo,
  output logic             wants_phase
);
  logic [NUM_TESTS-1:0] en;
  logic [NUM_TESTS-1:0] outcome;
  logic [NUM_TESTS-1:0] is_true;
  logic [NUM_TESTS-1:0] is_false;
  logic phase_hit;

  assign phase_hit = target_mode ? atn_active : (bus_phase == phase_field);

  assign en      = {ctrl[C_CARRY], ctrl[C_DATA], ctrl[C_PHASE]};
  assign outcome = {alu_carry, (first_byte == cmp_data), phase_hit};

  // A disabled test neither blocks a true branch nor a false branch
  for (genvar t = 0; t < NUM_TESTS; t++) begin : g_test
    assign is_true[t]  = ~en[t] | outcome[t];
    assign is_false[t] = ~en[t] | ~outcome[t];
  end

  always_comb begin
    if (ctrl[C_SENSE]) cond_met = &is_true;
    else               cond_met = (|en) & (&is_false);
  end

  assign bad_combo   = ctrl[C_CARRY] & (ctrl[C_DATA] | ctrl[C_PHASE]);
  assign wants_phase = ctrl[C_DATA] | ctrl[C_PHASE];
endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFS_W = 24
) (
  input  logic            relative,
  input  logic            go,
  input  logic [PC_W-1:0] addr_field,
  input  logic [PC_W-1:0] pc_seq,
  output logic [PC_W-1:0] next_pc
);
  localparam int unsigned EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] rel_pc;

  if (EXT_W > 0) begin : g_ext
    assign ofs_ext = {{EXT_W{addr_field[OFS_W-1]}}, addr_field[OFS_W-1:0]};
  end else begin : g_noext
    assign ofs_ext = addr_field;
  end

  assign rel_pc  = pc_seq + ofs_ext;
  assign next_pc = !go ? pc_seq : (relative ? rel_pc : addr_field);
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFS_W = 24,
  parameter int unsigned PH_W  = 3,
  parameter int unsigned DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [1:0]       op,
  input  logic [7:0]       ctrl,
  input  logic [PH_W-1:0]  phase_field,
  input  logic [DAT_W-1:0] cmp_data,
  input  logic [PC_W-1:0]  addr_field,
  input  logic [PC_W-1:0]  pc_seq,
  input  logic             alu_carry,
  input  logic [PH_W-1:0]  bus_phase,
  input  logic             phase_valid,
  input  logic [DAT_W-1:0] first_byte,
  input  logic             atn_active,
  input  logic             target_mode,
  output logic             res_valid,
  output logic             branch_taken,
  output logic [PC_W-1:0]  next_pc,
  output logic             ret_save,
  output logic [PC_W-1:0]  ret_addr,
  output logic             halt_req,
  output logic             int_fly,
  output logic             illegal
);
  logic cond_met, bad_combo, wants_phase;
  logic accept, go, is_int, is_call;
  logic [PC_W-1:0] pc_d;
  strobes_t st_d;
  op_e op_q;

  assign op_q = op_e'(op);

  brcond_eval #(.PH_W(PH_W), .DAT_W(DAT_W)) eval_i (
    .ctrl        (ctrl),
    .phase_field (phase_field),
    .cmp_data    (cmp_data),
    .alu_carry   (alu_carry),
    .bus_phase   (bus_phase),
    .first_byte  (first_byte),
    .atn_active  (atn_active),
    .target_mode (target_mode),
    .cond_met    (cond_met),
    .bad_combo   (bad_combo),
    .wants_phase (wants_phase)
  );

  // Hold off compares that must wait for a latched phase
  assign accept  = instr_valid & ~(ctrl[C_WAIT] & wants_phase & ~phase_valid);
  assign is_int  = (op_q == OP_INT);
  assign is_call = (op_q == OP_CALL);
  assign go      = cond_met & ~bad_combo & ~is_int;

  brcond_target #(.PC_W(PC_W), .OFS_W(OFS_W)) tgt_i (
    .relative   (ctrl[C_REL]),
    .go         (go),
    .addr_field (addr_field),
    .pc_seq     (pc_seq),
    .next_pc    (pc_d)
  );

  always_comb begin
    st_d         = '0;
    st_d.illegal = bad_combo;
    st_d.taken   = cond_met & ~bad_combo;
    st_d.save    = st_d.taken & is_call;
    st_d.halt    = st_d.taken & is_int & ~ctrl[C_FLY];
    st_d.fly     = st_d.taken & is_int & ctrl[C_FLY];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      branch_taken <= 1'b0;
      next_pc      <= '0;
      ret_save     <= 1'b0;
      ret_addr     <= '0;
      halt_req     <= 1'b0;
      int_fly      <= 1'b0;
      illegal      <= 1'b0;
    end else begin
      res_valid    <= accept;
      branch_taken <= accept & st_d.taken;
      ret_save     <= accept & st_d.save;
      halt_req     <= accept & st_d.halt;
      int_fly      <= accept & st_d.fly;
      illegal      <= accept & st_d.illegal;
      if (accept) begin
        next_pc  <= pc_d;
        ret_addr <= pc_seq;
      end
    end
  end
endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid,
  input logic [7:0]      ctrl,
  input logic            phase_valid,
  input logic [PC_W-1:0] pc_seq,
  input logic            res_valid,
  input logic            branch_taken,
  input logic            ret_save,
  input logic [PC_W-1:0] ret_addr,
  input logic            halt_req,
  input logic            int_fly,
  input logic            illegal
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid && !branch_taken && !ret_save && !halt_req && !int_fly && !illegal);

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !(ctrl[0] && (ctrl[2] || ctrl[1]) && !phase_valid) |=> res_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !branch_taken && !ret_save && !halt_req && !int_fly && !illegal);

  a_r8_illegal_no_action: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !branch_taken && !ret_save && !halt_req && !int_fly);

  a_r11_save_addr: assert property (@(posedge clk) disable iff (rst)
    ret_save |-> branch_taken && ret_addr == $past(pc_seq));

  a_r12_halt_or_fly: assert property (@(posedge clk) disable iff (rst)
    !(halt_req && int_fly));

  a_r13_wait_holds: assert property (@(posedge clk) disable iff (rst)
    instr_valid && ctrl[0] && (ctrl[2] || ctrl[1]) && !phase_valid |=> !res_valid);
endmodule

bind brcond_unit brcond_unit_chk #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .instr_valid  (instr_valid),
  .ctrl         (ctrl),
  .phase_valid  (phase_valid),
  .pc_seq       (pc_seq),
  .res_valid    (res_valid),
  .branch_taken (branch_taken),
  .ret_save     (ret_save),
  .ret_addr     (ret_addr),
  .halt_req     (halt_req),
  .int_fly      (int_fly),
  .illegal      (illegal)
);

// File: tb/brcond_unit_tb_top.sv
module brcond_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        instr_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [7:0]  ctrl = '0;
  logic [2:0]  phase_field = '0;
  logic [7:0]  cmp_data = '0;
  logic [31:0] addr_field = '0;
  logic [31:0] pc_seq = '0;
  logic        alu_carry = 1'b0;
  logic [2:0]  bus_phase = '0;
  logic        phase_valid = 1'b1;
  logic [7:0]  first_byte = '0;
  logic        atn_active = 1'b0;
  logic        target_mode = 1'b0;
  logic        res_valid, branch_taken, ret_save, halt_req, int_fly, illegal;
  logic [31:0] next_pc, ret_addr;

  brcond_unit dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .op(op), .ctrl(ctrl),
    .phase_field(phase_field), .cmp_data(cmp_data), .addr_field(addr_field),
    .pc_seq(pc_seq), .alu_carry(alu_carry), .bus_phase(bus_phase),
    .phase_valid(phase_valid), .first_byte(first_byte), .atn_active(atn_active),
    .target_mode(target_mode), .res_valid(res_valid), .branch_taken(branch_taken),
    .next_pc(next_pc), .ret_save(ret_save), .ret_addr(ret_addr),
    .halt_req(halt_req), .int_fly(int_fly), .illegal(illegal)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  ctrl;
    logic [2:0]  ph;
    logic [7:0]  cd;
    logic [31:0] addr;
    logic [31:0] seq;
    logic        carry;
    logic [2:0]  bph;
    logic [7:0]  fb;
    logic        atn;
    logic        tmode;
    logic        exp_taken;
    logic        exp_illegal;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h08, 3'd0, 8'h00, 32'hDEAD0000, 32'h00001000, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 uncond, abs R9
    '{2'd0, 8'h00, 3'd0, 8'h00, 32'hDEAD0000, 32'h00001008, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 none enabled, false sense
    '{2'd0, 8'h8C, 3'd0, 8'h5A, 32'h00000100, 32'h00001010, 1'b0, 3'd0, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 data true, rel
    '{2'd0, 8'h8C, 3'd0, 8'h5A, 32'h00000100, 32'h00001018, 1'b0, 3'd0, 8'h5B, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 data false
    '{2'd0, 8'h84, 3'd0, 8'h5A, 32'h00000100, 32'h00001020, 1'b0, 3'd0, 8'h5B, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 data false, false sense
    '{2'd0, 8'h0A, 3'd3, 8'h00, 32'h00002000, 32'h00001028, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 phase match
    '{2'd0, 8'h0A, 3'd3, 8'h00, 32'h00002000, 32'h00001030, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 target atn
    '{2'd0, 8'h02, 3'd3, 8'h00, 32'h00002000, 32'h00001038, 1'b0, 3'd3, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 target no atn, false sense
    '{2'd0, 8'h0E, 3'd5, 8'h11, 32'h00003000, 32'h00001040, 1'b0, 3'd5, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 both true
    '{2'd0, 8'h0E, 3'd5, 8'h11, 32'h00003000, 32'h00001048, 1'b0, 3'd4, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 mixed
    '{2'd0, 8'h06, 3'd5, 8'h11, 32'h00003000, 32'h00001050, 1'b0, 3'd4, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 mixed
    '{2'd0, 8'h06, 3'd5, 8'h11, 32'h00003000, 32'h00001058, 1'b0, 3'd4, 8'h12, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 both false
    '{2'd0, 8'h28, 3'd0, 8'h00, 32'h00004000, 32'h00001060, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 carry set
    '{2'd0, 8'h20, 3'd0, 8'h00, 32'h00004000, 32'h00001068, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 carry, false sense
    '{2'd0, 8'h2C, 3'd0, 8'h00, 32'h00004000, 32'h00001070, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 carry+data
    '{2'd1, 8'h22, 3'd0, 8'h00, 32'h00004000, 32'h00001078, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 carry+phase call
    '{2'd1, 8'h88, 3'd0, 8'h00, 32'h00FFFF00, 32'h00001080, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 call backward R9
    '{2'd2, 8'h08, 3'd0, 8'h00, 32'h00005000, 32'h00001088, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R12 int halts
    '{2'd2, 8'h18, 3'd0, 8'h00, 32'h00005000, 32'h00001090, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R12 int on the fly
    '{2'd1, 8'h80, 3'd0, 8'h00, 32'h00005000, 32'h00001098, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 call not taken
    '{2'd0, 8'h88, 3'd0, 8'h00, 32'h00000010, 32'hFFFFFFF8, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 wrap
    '{2'd3, 8'h08, 3'd0, 8'h00, 32'h12345678, 32'h000010A0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 reserved as jump
    '{2'd2, 8'h00, 3'd0, 8'h00, 32'h00005000, 32'h000010A8, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}  // R12 int not taken
  };

  task automatic apply(input vec_t v);
    @(negedge clk);
    op = v.op; ctrl = v.ctrl; phase_field = v.ph; cmp_data = v.cd;
    addr_field = v.addr; pc_seq = v.seq; alu_carry = v.carry; bus_phase = v.bph;
    first_byte = v.fb; atn_active = v.atn; target_mode = v.tmode; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // Expected outputs derived from the requirements
  task automatic check_vec(input vec_t v);
    logic [31:0] ofs, exp_pc;
    logic        jmp_like, is_int;
    ofs      = {{8{v.addr[23]}}, v.addr[23:0]};
    is_int   = (v.op == 2'd2);
    jmp_like = !is_int && v.exp_taken;
    exp_pc   = !jmp_like ? v.seq : (v.ctrl[7] ? v.seq + ofs : v.addr);
    check("R2 res_valid", {31'd0, res_valid}, 32'd1);
    check("R3/R4 taken", {31'd0, branch_taken}, {31'd0, v.exp_taken});
    check("R8 illegal", {31'd0, illegal}, {31'd0, v.exp_illegal});
    check("R9/R10 next_pc", next_pc, exp_pc);
    check("R11 ret_save", {31'd0, ret_save}, {31'd0, v.exp_taken && v.op == 2'd1});
    if (v.exp_taken && v.op == 2'd1) check("R11 ret_addr", ret_addr, v.seq);
    check("R12 halt_req", {31'd0, halt_req}, {31'd0, v.exp_taken && is_int && !v.ctrl[4]});
    check("R12 int_fly", {31'd0, int_fly}, {31'd0, v.exp_taken && is_int && v.ctrl[4]});
  endtask

  bit done = 1'b0;
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 reset next_pc", next_pc, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {26'd0, res_valid, branch_taken, ret_save, halt_req, int_fly, illegal}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_vec(VECS[i]);
    end

    @(negedge clk);
    check("R2 single-cycle result", {31'd0, res_valid}, 32'd0);

    // R13: deferred data compare
    phase_valid = 1'b0;
    op = 2'd0; ctrl = 8'h0D; cmp_data = 8'h33; first_byte = 8'h33;
    addr_field = 32'h0000_7000; pc_seq = 32'h0000_2000; instr_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R13 held without phase", {31'd0, res_valid}, 32'd0);
    end
    phase_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check("R13 result after phase", {31'd0, res_valid}, 32'd1);
    check("R13 taken after phase", next_pc, 32'h0000_7000);

    // R13: carry-only with wait bit is not held
    phase_valid = 1'b0;
    @(negedge clk);
    ctrl = 8'h29; alu_carry = 1'b1; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check("R13 carry not held", {31'd0, res_valid}, 32'd1);
    check("R7 carry taken", {31'd0, branch_taken}, 32'd1);
    phase_valid = 1'b1;

    // R1: reset in mid-flow clears a pending result
    @(negedge clk);
    ctrl = 8'h08; op = 2'd2; instr_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check("R1 reset dominates", {30'd0, res_valid, halt_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule